// File: doc/BRIEF.md
# Dual-Port Handshake Flag Bank

This block holds the handshake cells that two agents, a host and a device-side controller, use to signal state and commands to each other. Each 32-bit cell is split by ownership. One half belongs to the host and the other half belongs to the device. Each side may write only its own half and may read the whole cell. The bank has one system cell with 8-bit flag fields and four channel cells with 16-bit flag fields. Each port has a plain synchronous interface made of a byte address, a write enable, write data and registered read data.

A write by one side to a cell it partly owns sets a pending bit toward the other side. That side sees an interrupt, which is the OR of its pending bits. The receiving side clears a pending bit by pulsing the matching acknowledge bit. Addresses that map to no supported cell are inert: writes to them are dropped and reads from them return zero. When both ports write the same cell in the same cycle, each port changes only its own half.

Top module: `hsk_cell_bank`

## Requirements
- R1: After reset, every cell reads zero, all pending bits are 0 and both interrupt outputs are low.
- R2: In a channel cell, bits 31:16 belong to the host and bits 15:0 belong to the device. A host write changes only bits 31:16 and a device write changes only bits 15:0.
- R3: In the system cell, byte 3 holds the host flags and byte 2 holds the device flags. Bytes 1:0 are a data field that only the device may write. A host write changes only byte 3 and a device write changes only bytes 2:0.
- R4: Bits 7:2 of the address select the word and bits 1:0 are ignored. Word 0 is the system cell, and words 2, 3, 4 and 5 are channel cells 0 to 3.
- R5: Words 1 and 6 to 63 are unmapped. A write from either port to an unmapped word changes no cell and no pending bit, and a read from an unmapped word returns zero.
- R6: Read data is registered. The word addressed in one cycle appears on the read data output after the next rising edge, and the read data does not change before that edge.
- R7: A device write to a mapped cell sets bit k of the host pending vector, and a host write to a mapped cell sets bit k of the device pending vector. Here k is 0 for the system cell and 1+i for channel i. No other event sets a pending bit.
- R8: A 1 on an acknowledge bit clears the matching pending bit on that side. If a set and an acknowledge hit the same bit in the same cycle, the set wins.
- R9: Each side's interrupt output is high exactly when at least one of its pending bits is 1. The output goes high in the cycle after the write that sets the pending bit.
- R10: When both ports write the same mapped cell in the same cycle, both owned halves take their new values and both pending bits are set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| hostAddr | input | 8 | Host byte address for reads and writes |
| hostWrEn | input | 1 | Host write strobe |
| hostWrData | input | 32 | Host write data |
| hostRdData | output | 32 | Host registered read data |
| hostAck | input | 5 | Host write-1-to-clear for host pending bits |
| hostPend | output | 5 | Pending bits toward the host |
| hostIrq | output | 1 | Interrupt toward the host |
| devAddr | input | 8 | Device byte address for reads and writes |
| devWrEn | input | 1 | Device write strobe |
| devWrData | input | 32 | Device write data |
| devRdData | output | 32 | Device registered read data |
| devAck | input | 5 | Device write-1-to-clear for device pending bits |
| devPend | output | 5 | Pending bits toward the device |
| devIrq | output | 1 | Interrupt toward the device |

## Verification
The bench sweeps all 64 words from both ports. On each word it writes full 32-bit patterns whose halves differ, and it uses nonzero low address bits. A design that got this wrong would either let a non-owner overwrite the other half, alias the unused word or the reserved words onto real cells, or pass the system data bytes to the host. The bench also drives an acknowledge in the same cycle as a fresh set. A design with the wrong priority would lose that interrupt. The bench also issues two writes to one cell in the same cycle. A design that arbitrated between the ports would drop one half or one of the pending bits.

// File: rtl/hsk_pkg.sv
package hsk_pkg;
  localparam int HSK_CHANNELS   = 4;
  localparam int NUM_CELLS      = HSK_CHANNELS + 1;
  localparam int ADDR_W         = 8;
  localparam int CELL_W         = 32;
  localparam int WORD_W         = ADDR_W - 2;
  localparam int SYS_FLAG_W     = 8;
  localparam int SYS_DATA_W     = CELL_W - 2 * SYS_FLAG_W;
  localparam int CHAN_FLAG_W    = CELL_W / 2;
  localparam int SYS_WORD       = 0;
  localparam int CHAN_WORD_BASE = 2;

  typedef struct packed {
    logic [NUM_CELLS-1:0] hostWr;
    logic [NUM_CELLS-1:0] devWr;
    logic [NUM_CELLS-1:0] hostSel;
    logic [NUM_CELLS-1:0] devSel;
  } hsk_strobe_t;
endpackage

// File: rtl/hsk_ctrl.sv
module hsk_ctrl
  import hsk_pkg::*;
(
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic              hostWrEn,
  input  logic [ADDR_W-1:0] devAddr,
  input  logic              devWrEn,
  output hsk_strobe_t       strb
);
  logic [WORD_W-1:0]    hostWord;
  logic [WORD_W-1:0]    devWord;
  logic [NUM_CELLS-1:0] hostHit;
  logic [NUM_CELLS-1:0] devHit;

  assign hostWord = hostAddr[ADDR_W-1:2];
  assign devWord  = devAddr[ADDR_W-1:2];

  assign hostHit[0] = (hostWord == WORD_W'(SYS_WORD));
  assign devHit[0]  = (devWord == WORD_W'(SYS_WORD));

  generate
    for (genvar ch = 0; ch < HSK_CHANNELS; ch++) begin : g_dec
      assign hostHit[ch+1] = (hostWord == WORD_W'(CHAN_WORD_BASE + ch));
      assign devHit[ch+1]  = (devWord == WORD_W'(CHAN_WORD_BASE + ch));
    end
  endgenerate

  assign strb.hostSel = hostHit;
  assign strb.devSel  = devHit;
  assign strb.hostWr  = hostWrEn ? hostHit : '0;
  assign strb.devWr   = devWrEn ? devHit : '0;
endmodule

// File: rtl/hsk_datapath.sv
module hsk_datapath
  import hsk_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  hsk_strobe_t          strb,
  input  logic [CELL_W-1:0]    hostWrData,
  input  logic [CELL_W-1:0]    devWrData,
  input  logic [NUM_CELLS-1:0] hostAck,
  input  logic [NUM_CELLS-1:0] devAck,
  output logic [CELL_W-1:0]    hostRdData,
  output logic [CELL_W-1:0]    devRdData,
  output logic [NUM_CELLS-1:0] hostPend,
  output logic [NUM_CELLS-1:0] devPend
);
  logic [SYS_DATA_W-1:0] sysData;
  logic [SYS_FLAG_W-1:0] sysDevFlags;
  logic [SYS_FLAG_W-1:0] sysHostFlags;
  logic [CELL_W-1:0]     cellView [NUM_CELLS];
  logic [CELL_W-1:0]     hostMux;
  logic [CELL_W-1:0]     devMux;

  // system cell: device owns bytes 2..0, host owns byte 3
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sysData      <= '0;
      sysDevFlags  <= '0;
      sysHostFlags <= '0;
    end else begin
      if (strb.devWr[0]) begin
        sysData     <= devWrData[SYS_DATA_W-1:0];
        sysDevFlags <= devWrData[SYS_DATA_W +: SYS_FLAG_W];
      end
      if (strb.hostWr[0]) sysHostFlags <= hostWrData[CELL_W-1 -: SYS_FLAG_W];
    end
  end

  assign cellView[0] = {sysHostFlags, sysDevFlags, sysData};

  // channel cells: device owns low half, host owns high half
  generate
    for (genvar ch = 0; ch < HSK_CHANNELS; ch++) begin : g_chan
      logic [CHAN_FLAG_W-1:0] devHalf;
      logic [CHAN_FLAG_W-1:0] hostHalf;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          devHalf  <= '0;
          hostHalf <= '0;
        end else begin
          if (strb.devWr[ch+1])  devHalf  <= devWrData[CHAN_FLAG_W-1:0];
          if (strb.hostWr[ch+1]) hostHalf <= hostWrData[CELL_W-1 -: CHAN_FLAG_W];
        end
      end
      assign cellView[ch+1] = {hostHalf, devHalf};
    end
  endgenerate

  always_comb begin
    hostMux = '0;
    devMux  = '0;
    for (int k = 0; k < NUM_CELLS; k++) begin
      if (strb.hostSel[k]) hostMux = hostMux | cellView[k];
      if (strb.devSel[k])  devMux  = devMux | cellView[k];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hostRdData <= '0;
      devRdData  <= '0;
      hostPend   <= '0;
      devPend    <= '0;
    end else begin
      hostRdData <= hostMux;
      devRdData  <= devMux;
      // a fresh set takes priority over a same-cycle acknowledge
      hostPend   <= (hostPend & ~hostAck) | strb.devWr;
      devPend    <= (devPend & ~devAck) | strb.hostWr;
    end
  end
endmodule

// File: rtl/hsk_cell_bank.sv
module hsk_cell_bank
  import hsk_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [ADDR_W-1:0]    hostAddr,
  input  logic                 hostWrEn,
  input  logic [CELL_W-1:0]    hostWrData,
  output logic [CELL_W-1:0]    hostRdData,
  input  logic [NUM_CELLS-1:0] hostAck,
  output logic [NUM_CELLS-1:0] hostPend,
  output logic                 hostIrq,
  input  logic [ADDR_W-1:0]    devAddr,
  input  logic                 devWrEn,
  input  logic [CELL_W-1:0]    devWrData,
  output logic [CELL_W-1:0]    devRdData,
  input  logic [NUM_CELLS-1:0] devAck,
  output logic [NUM_CELLS-1:0] devPend,
  output logic                 devIrq
);
  hsk_strobe_t strb;

  hsk_ctrl u_ctrl (
    .hostAddr (hostAddr),
    .hostWrEn (hostWrEn),
    .devAddr  (devAddr),
    .devWrEn  (devWrEn),
    .strb     (strb)
  );

  hsk_datapath u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .hostWrData (hostWrData),
    .devWrData  (devWrData),
    .hostAck    (hostAck),
    .devAck     (devAck),
    .hostRdData (hostRdData),
    .devRdData  (devRdData),
    .hostPend   (hostPend),
    .devPend    (devPend)
  );

  assign hostIrq = |hostPend;
  assign devIrq  = |devPend;
endmodule

// File: rtl/hsk_cell_bank_chk.sv
module hsk_cell_bank_chk
  import hsk_pkg::*;
(
  input logic                 clk,
  input logic                 rstN,
  input logic [ADDR_W-1:0]    hostAddr,
  input logic                 hostWrEn,
  input logic [NUM_CELLS-1:0] hostAck,
  input logic [NUM_CELLS-1:0] hostPend,
  input logic                 hostIrq,
  input logic [ADDR_W-1:0]    devAddr,
  input logic                 devWrEn,
  input logic [NUM_CELLS-1:0] devAck,
  input logic [NUM_CELLS-1:0] devPend,
  input logic                 devIrq
);
  function automatic logic mapped(input logic [ADDR_W-1:0] a);
    int w;
    w = int'(a[ADDR_W-1:2]);
    return (w == SYS_WORD) || (w >= CHAN_WORD_BASE && w < CHAN_WORD_BASE + HSK_CHANNELS);
  endfunction

  assert_host_irq_source_R7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(hostIrq) |-> $past(devWrEn && mapped(devAddr)));

  assert_dev_irq_source_R7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(devIrq) |-> $past(hostWrEn && mapped(hostAddr)));

  assert_host_pend_quiet_R7: assert property (@(posedge clk) disable iff (!rstN)
    (!devWrEn && hostAck == '0) |=> $stable(hostPend));

  assert_ack_clears_R8: assert property (@(posedge clk) disable iff (!rstN)
    (hostAck == '1 && !devWrEn) |=> (hostPend == '0 && !hostIrq));

  assert_unmapped_ignored_R5: assert property (@(posedge clk) disable iff (!rstN)
    (hostWrEn && !mapped(hostAddr) && devAck == '0) |=> $stable(devPend));

  assert_irq_after_write_R9: assert property (@(posedge clk) disable iff (!rstN)
    (devWrEn && mapped(devAddr)) |=> hostIrq);
endmodule

bind hsk_cell_bank hsk_cell_bank_chk chk (.*);

// File: tb/hsk_cell_bank_test.sv
module hsk_cell_bank_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [7:0]  hostAddr = '0, devAddr = '0;
  logic        hostWrEn = 1'b0, devWrEn = 1'b0;
  logic [31:0] hostWrData = '0, devWrData = '0;
  logic [31:0] hostRdData, devRdData;
  logic [4:0]  hostAck = '0, devAck = '0;
  logic [4:0]  hostPend, devPend;
  logic        hostIrq, devIrq;

  int checks = 0;
  int errors = 0;
  logic [31:0] model [5];

  always #2.5 clk = ~clk;

  hsk_cell_bank uut (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic int cellOf(input int addr);
    int w;
    w = addr >> 2;
    if (w == 0) return 0;
    if (w >= 2 && w <= 5) return w - 1;
    return -1;
  endfunction

  function automatic logic [31:0] patH(input int w);
    return 32'hC3A5_0F00 ^ (w * 32'h0103_0507);
  endfunction

  function automatic logic [31:0] patD(input int w);
    return 32'h1E2D_3C4B + w * 32'h0709_0B0D;
  endfunction

  task automatic hostModel(input int c, input logic [31:0] d);
    if (c == 0) model[0][31:24] = d[31:24];
    else if (c > 0) model[c][31:16] = d[31:16];
  endtask

  task automatic devModel(input int c, input logic [31:0] d);
    if (c == 0) model[0][23:0] = d[23:0];
    else if (c > 0) model[c][15:0] = d[15:0];
  endtask

  task automatic ackAll(input string req);
    @(negedge clk);
    hostAck = '1; devAck = '1;
    @(negedge clk);
    hostAck = '0; devAck = '0;
    chk({req, " pending cleared host"}, 32'(hostPend), 32'h0);
    chk({req, " pending cleared dev"}, 32'(devPend), 32'h0);
    chk({"R9 irq low after ack"}, {30'h0, hostIrq, devIrq}, 32'h0);
  endtask

  task automatic readBoth(input int addr, output logic [31:0] h, output logic [31:0] d);
    @(negedge clk);
    hostAddr = 8'(addr); devAddr = 8'(addr);
    @(negedge clk);
    h = hostRdData; d = devRdData;
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual timeout expected completion");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : main
    logic [31:0] rh, rd;
    for (int k = 0; k < 5; k++) model[k] = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 host pending", 32'(hostPend), 32'h0);
    chk("R1 dev pending", 32'(devPend), 32'h0);
    chk("R1 irqs", {30'h0, hostIrq, devIrq}, 32'h0);
    for (int a = 0; a < 24; a += 4) begin
      readBoth(a, rh, rd);
      chk("R1 cell reads zero host", rh, 32'h0);
      chk("R1 cell reads zero dev", rd, 32'h0);
    end

    // sweep every word with nonzero low address bits (R4)
    for (int w = 0; w < 64; w++) begin
      int addr;
      int c;
      logic [31:0] expPend;
      addr = w * 4 + (w % 4);
      c = cellOf(addr);
      expPend = (c >= 0) ? (32'h1 << c) : 32'h0;
      // host write
      @(negedge clk);
      hostAddr = 8'(addr); hostWrEn = 1'b1; hostWrData = patH(w);
      @(negedge clk);
      hostWrEn = 1'b0;
      hostModel(c, patH(w));
      chk((c >= 0) ? "R7 dev pending after host write" : "R5 no dev pending on unmapped",
          32'(devPend), expPend);
      chk("R9 dev irq", {31'h0, devIrq}, (c >= 0) ? 32'h1 : 32'h0);
      chk("R7 host pending untouched by host write", 32'(hostPend), 32'h0);
      // device write
      @(negedge clk);
      devAddr = 8'(addr); devWrEn = 1'b1; devWrData = patD(w);
      @(negedge clk);
      devWrEn = 1'b0;
      devModel(c, patD(w));
      chk((c >= 0) ? "R7 host pending after dev write" : "R5 no host pending on unmapped",
          32'(hostPend), expPend);
      chk("R9 host irq", {31'h0, hostIrq}, (c >= 0) ? 32'h1 : 32'h0);
      // readback from both ports
      readBoth(addr, rh, rd);
      if (c < 0) begin
        chk("R5 unmapped reads zero host", rh, 32'h0);
        chk("R5 unmapped reads zero dev", rd, 32'h0);
      end else if (c == 0) begin
        chk("R3 system cell host read", rh, model[0]);
        chk("R3 system cell dev read", rd, model[0]);
      end else begin
        chk("R2 channel cell host read", rh, model[c]);
        chk("R2 channel cell dev read", rd, model[c]);
      end
      ackAll("R8");
    end

    // unmapped writes must not disturb any mapped cell (R5)
    for (int c = 0; c < 5; c++) begin
      readBoth((c == 0) ? 0 : (c + 1) * 4, rh, rd);
      chk("R5 mapped cell intact after sweep", rh, model[c]);
    end

    // R6 read latency: data holds until the next edge
    readBoth(8, rh, rd);
    @(negedge clk);
    hostAddr = 8'h10;
    #1;
    chk("R6 read data before edge", hostRdData, model[1]);
    @(negedge clk);
    chk("R6 read data after edge", hostRdData, model[3]);

    // R8 set wins over same-cycle acknowledge
    @(negedge clk);
    devAddr = 8'h08; devWrEn = 1'b1; devWrData = 32'hFFFF_0001; hostAck = '1;
    @(negedge clk);
    devWrEn = 1'b0; hostAck = '0;
    devModel(1, 32'hFFFF_0001);
    chk("R8 set beats ack", 32'(hostPend), 32'h2);
    ackAll("R8");

    // R10 simultaneous writes to one channel cell and to the system cell
    @(negedge clk);
    hostAddr = 8'h10; devAddr = 8'h10; hostWrEn = 1'b1; devWrEn = 1'b1;
    hostWrData = 32'hBEEF_1111; devWrData = 32'h2222_CAFE;
    @(negedge clk);
    hostWrEn = 1'b0; devWrEn = 1'b0;
    hostModel(3, 32'hBEEF_1111); devModel(3, 32'h2222_CAFE);
    chk("R10 both pending host", 32'(hostPend), 32'h8);
    chk("R10 both pending dev", 32'(devPend), 32'h8);
    readBoth(8'h10, rh, rd);
    chk("R10 merged channel cell", rh, 32'hBEEF_CAFE);
    @(negedge clk);
    hostAddr = 8'h00; devAddr = 8'h00; hostWrEn = 1'b1; devWrEn = 1'b1;
    hostWrData = 32'h5A00_0000; devWrData = 32'h00C3_9876;
    @(negedge clk);
    hostWrEn = 1'b0; devWrEn = 1'b0;
    readBoth(0, rh, rd);
    chk("R10 merged system cell", rd, 32'h5AC3_9876);
    ackAll("R8");

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule